// File: doc/BRIEF.md
# SPI Channel Word Sequencer

This block controls the word exchanges of a single SPI channel. It keeps three status flags for the channel: a received word is waiting, the transmit holding register is empty, and a word has finished. From these flags and the channel settings (enable, direction mode, turbo, word length and the two DMA enables) it decides when the next word may go out. It starts that word on a separate serial shifter through a start/done handshake. It also raises one-cycle event pulses for an interrupt unit and holds DMA request levels for a DMA engine.

A register unit in front of the block decodes software accesses. It passes in the configuration as plain levels, a one-cycle strobe when the transmit register is written, and a one-cycle strobe when the receive register is read. Pin-level clocking belongs to the shifter.

Top module: `spi_seq_chan`

## Requirements
- R1: After reset, `status_o` is 3'b010 (bit 0 = receive-full, bit 1 = transmit-empty, bit 2 = end-of-word). After reset `sh_start`, both DMA requests and both event pulses are low.
- R2: `sh_start` is high exactly when all of the following hold: `cfg_en` is 1; no word is in flight; receive-full is not blocking; transmit-empty is not blocking. Receive-full blocks when it is set, `cfg_mode` is not 2 and `cfg_turbo` is 0. Transmit-empty blocks when it is set and `cfg_mode` is not 1. Mode encoding: 0 full duplex, 1 receive only, 2 transmit only. The reserved value 3 behaves like 0.
- R3: `sh_start` lasts one cycle. While it is high, `sh_txword` presents the stored transmit word and `sh_len` presents the word length in bits. After a start, no further start occurs until `sh_done` is sampled high. `sh_done` is ignored when no word is in flight.
- R4: A word completes at the edge where `sh_done` is sampled high with a word in flight. That edge sets end-of-word and transmit-empty. It also sets receive-full unless `cfg_mode` is 2. End-of-word then stays set until reset.
- R5: At a completion edge, `rx_rdata` takes `sh_rxword` with all bits at or above the word length cleared.
- R6: The word length is `cfg_wlen_m1` + 1. Field values below 3 are treated as 3, so the shortest word is 4 bits.
- R7: A `tx_wr` strobe stores `tx_wdata` and clears transmit-empty, and it takes priority over a completion in the same cycle. An `rx_rd` strobe clears receive-full, but a completion in the same cycle keeps it set.
- R8: `dma_tx_req` = `cfg_en` AND `cfg_txdma_en` AND transmit-empty AND (mode != 1). `dma_rx_req` = `cfg_en` AND `cfg_rxdma_en` AND receive-full AND (mode != 2). Both are evaluated on the current flags.
- R9: On the cycle after a completion, `evt_tx_empty` pulses when mode != 1. `evt_rx_full` pulses when mode != 2 and turbo is off.
- R10: On the cycle after `cfg_en` goes from 0 to 1, `evt_tx_empty` pulses if transmit-empty is set and mode != 1. `evt_rx_full` pulses if receive-full is set, mode != 2 and turbo is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Channel enable |
| cfg_mode | input | 2 | Direction mode (0 duplex, 1 rx only, 2 tx only) |
| cfg_wlen_m1 | input | LW | Word length minus one |
| cfg_turbo | input | 1 | Turbo: a pending received word does not block a start |
| cfg_txdma_en | input | 1 | Transmit DMA enable |
| cfg_rxdma_en | input | 1 | Receive DMA enable |
| tx_wr | input | 1 | Transmit register write strobe |
| tx_wdata | input | DW | Transmit word |
| rx_rd | input | 1 | Receive register read strobe |
| rx_rdata | output | DW | Last received word, masked to length |
| status_o | output | 3 | {end-of-word, transmit-empty, receive-full} |
| sh_start | output | 1 | Start a word on the shifter |
| sh_txword | output | DW | Word to shift out |
| sh_len | output | LW+1 | Word length in bits |
| sh_done | input | 1 | Shifter finished the word |
| sh_rxword | input | DW | Word captured by the shifter |
| evt_tx_empty | output | 1 | Transmit-empty event pulse |
| evt_rx_full | output | 1 | Receive-full event pulse |
| dma_tx_req | output | 1 | Transmit DMA request level |
| dma_rx_req | output | 1 | Receive DMA request level |

## Verification
The assertions check the following on every cycle: no start while disabled, no back-to-back starts, transmit-empty set after an unopposed completion, and receive-full cleared after a read that does not collide with a completion. They also check the reset value of the flags and that no receive event appears in transmit-only or turbo operation. The bench sweeps every mode, both turbo settings and clamped, middle and full word lengths. This is how the collision priorities, the masking of received words, the events on an enable rise and the continuous restarts of turbo and receive-only operation are shown.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

    typedef enum logic [1:0] {
        XM_DUPLEX  = 2'd0,
        XM_RX_ONLY = 2'd1,
        XM_TX_ONLY = 2'd2,
        XM_RSVD    = 2'd3
    } xfer_mode_e;

    // bit 2 end-of-word, bit 1 transmit-empty, bit 0 receive-full
    typedef struct packed {
        logic eot;
        logic txe;
        logic rxf;
    } chan_stat_t;

    localparam chan_stat_t STAT_RESET = '{eot: 1'b0, txe: 1'b1, rxf: 1'b0};

    // smallest legal value of the length-minus-one field
    localparam int MIN_WLEN_M1 = 3;

endpackage

// File: rtl/spi_seq_len.sv
module spi_seq_len #(
    parameter int DW = 32,
    localparam int LW = $clog2(DW)
) (
    input  logic [LW-1:0] wlen_m1,
    output logic [LW:0]   len,
    output logic [DW-1:0] mask
);
    import spi_seq_pkg::*;

    logic [LW-1:0] eff_m1;

    always_comb begin
        if (wlen_m1 < LW'(MIN_WLEN_M1)) eff_m1 = LW'(MIN_WLEN_M1);
        else                             eff_m1 = wlen_m1;
        len = (LW+1)'(eff_m1) + (LW+1)'(1);
    end

    for (genvar i = 0; i < DW; i++) begin : g_mask
        assign mask[i] = (i <= int'(eff_m1));
    end

endmodule

// File: rtl/spi_seq_gate.sv
module spi_seq_gate
    import spi_seq_pkg::*;
(
    input  logic       en,
    input  xfer_mode_e mode,
    input  logic       turbo,
    input  logic       txdma_en,
    input  logic       rxdma_en,
    input  chan_stat_t stat,
    input  logic       busy,
    output logic       may_start,
    output logic       tx_side,
    output logic       rx_side,
    output logic       rx_evt_ok,
    output logic       dma_tx,
    output logic       dma_rx
);
    logic rx_block;
    logic tx_block;

    always_comb begin
        tx_side   = (mode != XM_RX_ONLY);
        rx_side   = (mode != XM_TX_ONLY);
        rx_evt_ok = rx_side && !turbo;
        rx_block  = stat.rxf && rx_side && !turbo;
        tx_block  = stat.txe && tx_side;
        may_start = en && !busy && !rx_block && !tx_block;
        dma_tx    = en && txdma_en && stat.txe && tx_side;
        dma_rx    = en && rxdma_en && stat.rxf && rx_side;
    end

endmodule

// File: rtl/spi_seq_core.sv
module spi_seq_core
    import spi_seq_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          tx_side,
    input  logic          rx_side,
    input  logic          rx_evt_ok,
    input  logic          may_start,
    input  logic          tx_wr,
    input  logic [DW-1:0] tx_wdata,
    input  logic          rx_rd,
    input  logic          sh_done,
    input  logic [DW-1:0] sh_rxword,
    input  logic [DW-1:0] rx_mask,
    output chan_stat_t    stat_o,
    output logic          busy_o,
    output logic [DW-1:0] tx_word_o,
    output logic [DW-1:0] rx_word_o,
    output logic          evt_tx_o,
    output logic          evt_rx_o
);
    typedef struct packed {
        chan_stat_t    stat;
        logic          busy;
        logic          en_prev;
        logic          evt_tx;
        logic          evt_rx;
        logic [DW-1:0] tx_word;
        logic [DW-1:0] rx_word;
    } core_state_t;

    localparam core_state_t CORE_RESET = '{
        stat:    STAT_RESET,
        busy:    1'b0,
        en_prev: 1'b0,
        evt_tx:  1'b0,
        evt_rx:  1'b0,
        tx_word: '0,
        rx_word: '0
    };

    core_state_t state_d, state_q;
    logic        complete;
    logic        en_rise;

    always_comb begin
        state_d  = state_q;
        complete = state_q.busy && sh_done;
        en_rise  = en && !state_q.en_prev;

        state_d.en_prev = en;

        if (may_start)     state_d.busy = 1'b1;
        else if (complete) state_d.busy = 1'b0;

        if (tx_wr) state_d.tx_word = tx_wdata;

        if (complete) begin
            state_d.stat.eot = 1'b1;
            state_d.rx_word  = sh_rxword & rx_mask;
        end

        if (tx_wr)         state_d.stat.txe = 1'b0;
        else if (complete) state_d.stat.txe = 1'b1;

        if (complete && rx_side) state_d.stat.rxf = 1'b1;
        else if (rx_rd)          state_d.stat.rxf = 1'b0;

        state_d.evt_tx = (complete || (en_rise && state_q.stat.txe)) && tx_side;
        state_d.evt_rx = (complete || (en_rise && state_q.stat.rxf)) && rx_evt_ok;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CORE_RESET;
        else        state_q <= state_d;
    end

    assign stat_o    = state_q.stat;
    assign busy_o    = state_q.busy;
    assign tx_word_o = state_q.tx_word;
    assign rx_word_o = state_q.rx_word;
    assign evt_tx_o  = state_q.evt_tx;
    assign evt_rx_o  = state_q.evt_rx;

    // a completion without a competing write leaves transmit-empty set
    assert_done_sets_txe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && sh_done && !tx_wr) |=> stat_o.txe);

    // a read that does not collide with a completion empties the receive side
    assert_read_clears_rxf_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd && !(busy_o && sh_done)) |=> !stat_o.rxf);

    // a launched word stays in flight until the shifter reports done
    assert_flight_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !sh_done) |=> busy_o);

endmodule

// File: rtl/spi_seq_chan.sv
module spi_seq_chan
    import spi_seq_pkg::*;
#(
    parameter int DW = 32,
    localparam int LW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_en,
    input  logic [1:0]    cfg_mode,
    input  logic [LW-1:0] cfg_wlen_m1,
    input  logic          cfg_turbo,
    input  logic          cfg_txdma_en,
    input  logic          cfg_rxdma_en,
    input  logic          tx_wr,
    input  logic [DW-1:0] tx_wdata,
    input  logic          rx_rd,
    output logic [DW-1:0] rx_rdata,
    output logic [2:0]    status_o,
    output logic          sh_start,
    output logic [DW-1:0] sh_txword,
    output logic [LW:0]   sh_len,
    input  logic          sh_done,
    input  logic [DW-1:0] sh_rxword,
    output logic          evt_tx_empty,
    output logic          evt_rx_full,
    output logic          dma_tx_req,
    output logic          dma_rx_req
);
    chan_stat_t    stat;
    logic          busy;
    logic          may_start;
    logic          tx_side;
    logic          rx_side;
    logic          rx_evt_ok;
    logic [DW-1:0] rx_mask;

    spi_seq_len #(.DW(DW)) u_len (
        .wlen_m1 (cfg_wlen_m1),
        .len     (sh_len),
        .mask    (rx_mask)
    );

    spi_seq_gate u_gate (
        .en        (cfg_en),
        .mode      (xfer_mode_e'(cfg_mode)),
        .turbo     (cfg_turbo),
        .txdma_en  (cfg_txdma_en),
        .rxdma_en  (cfg_rxdma_en),
        .stat      (stat),
        .busy      (busy),
        .may_start (may_start),
        .tx_side   (tx_side),
        .rx_side   (rx_side),
        .rx_evt_ok (rx_evt_ok),
        .dma_tx    (dma_tx_req),
        .dma_rx    (dma_rx_req)
    );

    spi_seq_core #(.DW(DW)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (cfg_en),
        .tx_side   (tx_side),
        .rx_side   (rx_side),
        .rx_evt_ok (rx_evt_ok),
        .may_start (may_start),
        .tx_wr     (tx_wr),
        .tx_wdata  (tx_wdata),
        .rx_rd     (rx_rd),
        .sh_done   (sh_done),
        .sh_rxword (sh_rxword),
        .rx_mask   (rx_mask),
        .stat_o    (stat),
        .busy_o    (busy),
        .tx_word_o (sh_txword),
        .rx_word_o (rx_rdata),
        .evt_tx_o  (evt_tx_empty),
        .evt_rx_o  (evt_rx_full)
    );

    assign sh_start = may_start;
    assign status_o = stat;

    assert_reset_flags_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (status_o == 3'b010));

    assert_no_start_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |-> !sh_start);

    assert_single_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sh_start |=> !sh_start);

    assert_dma_rx_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dma_rx_req |-> (cfg_en && status_o[0] && cfg_mode != 2'd2));

    assert_rx_evt_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
        evt_rx_full |-> ($past(cfg_mode) != 2'd2 && !$past(cfg_turbo)));

endmodule

// File: tb/spi_seq_chan_tb.sv
`timescale 1ns/1ps
module spi_seq_chan_tb;
    localparam int DW = 32;
    localparam int LW = $clog2(DW);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_en = 1'b0;
    logic [1:0]    cfg_mode = 2'd0;
    logic [LW-1:0] cfg_wlen_m1 = '0;
    logic          cfg_turbo = 1'b0;
    logic          cfg_txdma_en = 1'b0;
    logic          cfg_rxdma_en = 1'b0;
    logic          tx_wr = 1'b0;
    logic [DW-1:0] tx_wdata = '0;
    logic          rx_rd = 1'b0;
    logic [DW-1:0] rx_rdata;
    logic [2:0]    status_o;
    logic          sh_start;
    logic [DW-1:0] sh_txword;
    logic [LW:0]   sh_len;
    logic          sh_done = 1'b0;
    logic [DW-1:0] sh_rxword = '0;
    logic          evt_tx_empty;
    logic          evt_rx_full;
    logic          dma_tx_req;
    logic          dma_rx_req;

    spi_seq_chan #(.DW(DW)) u_dut (.*);

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // bench model of the channel flags
    logic          m_rxf, m_txe, m_eot, m_busy, m_en;
    logic [DW-1:0] m_tx, m_rx;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog actual %0d expected below 150000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic tx_side_f();
        return cfg_mode != 2'd1;
    endfunction

    function automatic logic rx_side_f();
        return cfg_mode != 2'd2;
    endfunction

    function automatic logic [LW:0] exp_len();
        return (cfg_wlen_m1 < 3) ? (LW+1)'(4) : (LW+1)'(cfg_wlen_m1) + (LW+1)'(1);
    endfunction

    function automatic logic [DW-1:0] exp_mask();
        int n = int'(exp_len());
        return (n >= DW) ? '1 : ((DW'(1) << n) - DW'(1));
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cfg_en = 1'b0; tx_wr = 1'b0; rx_rd = 1'b0; sh_done = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_rxf = 1'b0; m_txe = 1'b1; m_eot = 1'b0; m_busy = 1'b0; m_en = 1'b0;
        m_tx = '0; m_rx = '0;
        #1;
        chk(status_o === 3'b010, "R1 reset status", DW'(status_o), DW'(3'b010));
        chk(!sh_start && !dma_tx_req && !dma_rx_req && !evt_tx_empty && !evt_rx_full,
            "R1 reset outputs quiet",
            DW'({sh_start, dma_tx_req, dma_rx_req, evt_tx_empty, evt_rx_full}), '0);
    endtask

    task automatic step(input logic en, input logic wr, input logic [DW-1:0] wd,
                        input logic rd, input logic done, input logic [DW-1:0] rw);
        logic start_exp, complete, en_rise, etx, erx, dtx, drx;
        @(negedge clk);
        cfg_en = en; tx_wr = wr; tx_wdata = wd; rx_rd = rd; sh_done = done; sh_rxword = rw;
        #1;
        // R2 start rule from the flags and settings
        start_exp = en && !m_busy && !(m_rxf && rx_side_f() && !cfg_turbo)
                    && !(m_txe && tx_side_f());
        chk(sh_start === start_exp, "R2 start permission", DW'(sh_start), DW'(start_exp));
        if (m_busy) chk(sh_start === 1'b0, "R3 hold-off while in flight", DW'(sh_start), '0);
        if (start_exp) begin
            chk(sh_txword === m_tx, "R3 start word", sh_txword, m_tx);
            chk(sh_len === exp_len(), "R6 word length", DW'(sh_len), DW'(exp_len()));
        end
        complete = m_busy && done;
        en_rise  = en && !m_en;
        etx = (complete || (en_rise && m_txe)) && tx_side_f();
        erx = (complete || (en_rise && m_rxf)) && rx_side_f() && !cfg_turbo;
        m_en = en;
        if (start_exp) m_busy = 1'b1;
        else if (complete) m_busy = 1'b0;
        if (wr) m_tx = wd;
        if (complete) begin
            m_eot = 1'b1;
            m_rx  = rw & exp_mask();
        end
        if (wr) m_txe = 1'b0;
        else if (complete) m_txe = 1'b1;
        if (complete && rx_side_f()) m_rxf = 1'b1;
        else if (rd) m_rxf = 1'b0;
        @(posedge clk);
        #5;
        chk(status_o === {m_eot, m_txe, m_rxf}, "R4 R7 status flags",
            DW'(status_o), DW'({m_eot, m_txe, m_rxf}));
        chk(rx_rdata === m_rx, "R5 received word", rx_rdata, m_rx);
        chk(evt_tx_empty === etx, "R9 R10 tx event", DW'(evt_tx_empty), DW'(etx));
        chk(evt_rx_full === erx, "R9 R10 rx event", DW'(evt_rx_full), DW'(erx));
        dtx = en && cfg_txdma_en && m_txe && tx_side_f();
        drx = en && cfg_rxdma_en && m_rxf && rx_side_f();
        chk(dma_tx_req === dtx, "R8 tx dma", DW'(dma_tx_req), DW'(dtx));
        chk(dma_rx_req === drx, "R8 rx dma", DW'(dma_rx_req), DW'(drx));
    endtask

    initial begin
        m_rxf = 1'b0; m_txe = 1'b1; m_eot = 1'b0; m_busy = 1'b0; m_en = 1'b0;
        m_tx = '0; m_rx = '0;
        for (int m = 0; m < 4; m++) begin
            for (int t = 0; t < 2; t++) begin
                for (int wi = 0; wi < 3; wi++) begin
                    logic [DW-1:0] seed;
                    cfg_mode     = 2'(m);
                    cfg_turbo    = t[0];
                    cfg_wlen_m1  = (wi == 0) ? LW'(1) : (wi == 1) ? LW'(12) : LW'(DW-1);
                    cfg_txdma_en = t[0] ^ m[0];
                    cfg_rxdma_en = !t[0] | m[1];
                    seed = DW'(32'h9E37_79B9) * DW'(m * 8 + t * 4 + wi + 1);
                    do_reset();
                    step(0, 1, seed ^ 32'h1234_5678, 0, 0, '0);       // write while disabled
                    step(0, 0, '0, 0, 1, seed ^ 32'hFFFF_0000);        // stray done ignored
                    step(1, 0, '0, 0, 0, '0);                          // enable rise
                    step(1, 0, '0, 0, 0, '0);
                    step(1, 0, '0, 0, 1, seed ^ 32'hDEAD_BEEF);        // completion
                    step(1, 0, '0, 0, 0, '0);
                    step(1, 1, seed ^ 32'h0F0F_0F0F, 1, 1, ~seed);     // write, read, done together
                    step(1, 0, '0, 0, 1, seed ^ 32'hA5A5_5A5A);
                    step(1, 0, '0, 1, 0, '0);
                    step(1, 1, seed ^ 32'h3C3C_C3C3, 0, 0, '0);
                    step(1, 0, '0, 0, 1, seed ^ 32'h7777_1111);
                    step(0, 0, '0, 0, 0, '0);
                    step(1, 0, '0, 0, 0, '0);                          // enable rise with flags set
                    step(1, 0, '0, 0, 1, seed ^ 32'h0123_4567);
                    step(1, 0, '0, 1, 0, '0);
                    step(1, 0, '0, 0, 1, seed);
                end
            end
        end
        @(negedge clk);
        tx_wr = 1'b0; rx_rd = 1'b0; sh_done = 1'b0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule